// File: doc/BRIEF.md
# Turbo Decoding Iteration Controller

This block sequences the iterative decoding of one stored frame by a single shared component decoder. It alternates the decoder between a natural-order half-iteration and an interleaved-order half-iteration. In each half it selects the parity source and the read and write addressing, starts the decoder and waits for it to finish. After a fixed number of full iterations it reads the final log-likelihood ratios in natural order and delivers hard decisions taken from their signs.

The decoder walks a linear index for reads and writes. In natural halves that index is the memory address. In interleaved halves the controller sends the index to an external permutation table and uses the permuted address, for reads and for the extrinsic/LLR writeback alike. As a result the shared extrinsic store always holds values in natural order. The next natural pass therefore reads deinterleaved data, and the next interleaved pass reads interleaved data, with no second memory.

Top module: `turbo_iter_ctrl`

## Requirements
- R1: After reset, dec_start_o, done_o, hard_valid_o, dec_half_o and apriori_zero_o are 0 and iter_o is 0.
- R2: A frame consists of ITERS (default 6) full iterations, each a natural half followed by an interleaved half, so the decoder is started exactly 2*ITERS times. iter_o is 0 for the first iteration, rises by one after each interleaved half and holds ITERS-1 in the last iteration.
- R3: Each half begins with dec_start_o high for exactly one cycle. dec_half_o (0 = natural, 1 = interleaved) is already valid in that cycle and holds until the half ends.
- R4: apriori_zero_o is 1 only during the natural half of iteration 0, including its start cycle, and is 0 in all later halves.
- R5: While dec_half_o is 0, mem_rd_addr_o equals dec_rd_idx_i and mem_wr_addr_o equals dec_wr_idx_i. While dec_half_o is 1, they equal perm_rd_addr_i and perm_wr_addr_i, which are the table lookups of perm_rd_idx_o = dec_rd_idx_i and perm_wr_idx_o = dec_wr_idx_i. The routing is combinational and has no cycle of delay.
- R6: dec_done_i ends a half only when sampled after the start cycle. A done that is high in the start cycle itself is ignored.
- R7: After the last interleaved half, llr_addr_o steps through 0..FRAME_LEN-1, one address per cycle. The LLR memory answers one cycle later. In that cycle hard_valid_o is 1, hard_idx_o is the address, and hard_bit_o is 1 when the two's-complement llr_i is zero or positive and 0 when it is negative.
- R8: done_o is a one-cycle pulse in the same cycle as the last hard decision (index FRAME_LEN-1). The controller is idle on the following cycle.
- R9: start_i is ignored in every state except idle, including the cycle in which done_o is high. A start in any other state neither resets iter_o nor begins a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin decoding the stored frame (accepted in idle only) |
| dec_start_o | output | 1 | One-cycle start to the component decoder |
| dec_done_i | input | 1 | Component decoder finished its half |
| dec_half_o | output | 1 | 0 = natural half (first parity), 1 = interleaved half (second parity) |
| apriori_zero_o | output | 1 | Force the a-priori input to zero |
| iter_o | output | CNT_W (3) | Current iteration, counting from 0 |
| dec_rd_idx_i | input | ADDR_W | Linear read index from the decoder |
| dec_wr_idx_i | input | ADDR_W | Linear write index from the decoder |
| perm_rd_idx_o | output | ADDR_W | Permutation table lookup, read path |
| perm_rd_addr_i | input | ADDR_W | Permuted read address |
| perm_wr_idx_o | output | ADDR_W | Permutation table lookup, write path |
| perm_wr_addr_i | input | ADDR_W | Permuted write address |
| mem_rd_addr_o | output | ADDR_W | Frame/extrinsic memory read address |
| mem_wr_addr_o | output | ADDR_W | Extrinsic/LLR memory write address |
| llr_addr_o | output | ADDR_W | Final LLR read address during output |
| llr_i | input | LLR_W | Final LLR read data (one-cycle latency) |
| hard_valid_o | output | 1 | Hard decision valid |
| hard_bit_o | output | 1 | Hard decision |
| hard_idx_o | output | ADDR_W | Frame index of the hard decision |
| done_o | output | 1 | Frame finished |

## Verification
dec_start_o rises in the second cycle after the cycle that carries start_i. Each later start follows the accepting done by one cycle: the controller moves on at the edge that samples done and starts the next half in that same new cycle. The address routing is combinational, so the bench drives an index and checks the resulting address within the same cycle. A hard decision appears one cycle after its llr_addr_o, matching the bench's one-cycle memory model, and done_o coincides with the last decision. The bench drives every input on the falling edge and samples every output on the falling edge, half a period clear of the active edge, so each check lands in the cycle worked out above.

// File: rtl/turbo_ctrl_pkg.sv
package turbo_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_H1_RUN,
    ST_H1_WAIT,
    ST_H2_RUN,
    ST_H2_WAIT,
    ST_OUTPUT,
    ST_DONE
  } ctrl_state_e;
endpackage

// File: rtl/turbo_seq_fsm.sv
module turbo_seq_fsm
  import turbo_ctrl_pkg::*;
#(
  parameter int ITERS = 6,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dec_done_i,
  input  logic             out_last_i,
  output ctrl_state_e      state_o,
  output logic [CNT_W-1:0] iter_o
);
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(ITERS - 1);

  ctrl_state_e state_q, state_d;
  logic [CNT_W-1:0] iter_q;
  logic last_iter;

  assign last_iter = (iter_q == LAST_ITER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_H1_RUN;
      ST_H1_RUN:  state_d = ST_H1_WAIT;
      ST_H1_WAIT: if (dec_done_i) state_d = ST_H2_RUN;
      ST_H2_RUN:  state_d = ST_H2_WAIT;
      ST_H2_WAIT: if (dec_done_i) state_d = last_iter ? ST_OUTPUT : ST_H1_RUN;
      ST_OUTPUT:  if (out_last_i) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i)
        iter_q <= '0;
      else if (state_q == ST_H2_WAIT && dec_done_i && !last_iter)
        iter_q <= iter_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign iter_o  = iter_q;
endmodule

// File: rtl/turbo_addr_route.sv
module turbo_addr_route #(
  parameter int ADDR_W = 6,
  parameter int PORTS  = 2
) (
  input  logic                         interleave_i,
  input  logic [PORTS-1:0][ADDR_W-1:0] nat_idx_i,
  input  logic [PORTS-1:0][ADDR_W-1:0] perm_addr_i,
  output logic [PORTS-1:0][ADDR_W-1:0] addr_o
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign addr_o[p] = interleave_i ? perm_addr_i[p] : nat_idx_i[p];
  end
endmodule

// File: rtl/turbo_hard_out.sv
module turbo_hard_out #(
  parameter int FRAME_LEN = 64,
  parameter int ADDR_W    = 6,
  parameter int LLR_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [LLR_W-1:0]  llr_i,
  output logic [ADDR_W-1:0] llr_addr_o,
  output logic              last_o,
  output logic              hard_valid_o,
  output logic              hard_bit_o,
  output logic [ADDR_W-1:0] hard_idx_o
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(FRAME_LEN - 1);

  logic [ADDR_W-1:0] cnt_q, idx_q;
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= active_i ? cnt_q + 1'b1 : '0;
      pend_q <= active_i;
      idx_q  <= cnt_q;
    end
  end

  assign llr_addr_o   = cnt_q;
  assign last_o       = active_i && (cnt_q == LAST_IDX);
  assign hard_valid_o = pend_q;
  assign hard_idx_o   = idx_q;
  // non-negative LLR decides 1
  assign hard_bit_o   = ~llr_i[LLR_W-1];
endmodule

// File: rtl/turbo_iter_ctrl.sv
module turbo_iter_ctrl
  import turbo_ctrl_pkg::*;
#(
  parameter int FRAME_LEN = 64,
  parameter int ITERS     = 6,
  parameter int LLR_W     = 8,
  localparam int ADDR_W   = $clog2(FRAME_LEN),
  localparam int CNT_W    = $clog2(ITERS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              dec_start_o,
  input  logic              dec_done_i,
  output logic              dec_half_o,
  output logic              apriori_zero_o,
  output logic [CNT_W-1:0]  iter_o,
  input  logic [ADDR_W-1:0] dec_rd_idx_i,
  input  logic [ADDR_W-1:0] dec_wr_idx_i,
  output logic [ADDR_W-1:0] perm_rd_idx_o,
  input  logic [ADDR_W-1:0] perm_rd_addr_i,
  output logic [ADDR_W-1:0] perm_wr_idx_o,
  input  logic [ADDR_W-1:0] perm_wr_addr_i,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [ADDR_W-1:0] llr_addr_o,
  input  logic [LLR_W-1:0]  llr_i,
  output logic              hard_valid_o,
  output logic              hard_bit_o,
  output logic [ADDR_W-1:0] hard_idx_o,
  output logic              done_o
);
  ctrl_state_e state;
  logic out_last;
  logic [1:0][ADDR_W-1:0] nat_idx, perm_addr, route_addr;

  turbo_seq_fsm #(.ITERS(ITERS), .CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .dec_done_i (dec_done_i),
    .out_last_i (out_last),
    .state_o    (state),
    .iter_o     (iter_o)
  );

  assign dec_start_o    = (state == ST_H1_RUN) || (state == ST_H2_RUN);
  assign dec_half_o     = (state == ST_H2_RUN) || (state == ST_H2_WAIT);
  assign apriori_zero_o = ((state == ST_H1_RUN) || (state == ST_H1_WAIT)) && (iter_o == '0);
  assign done_o         = (state == ST_DONE);

  assign perm_rd_idx_o = dec_rd_idx_i;
  assign perm_wr_idx_o = dec_wr_idx_i;
  assign nat_idx       = {dec_wr_idx_i, dec_rd_idx_i};
  assign perm_addr     = {perm_wr_addr_i, perm_rd_addr_i};

  turbo_addr_route #(.ADDR_W(ADDR_W), .PORTS(2)) u_route (
    .interleave_i (dec_half_o),
    .nat_idx_i    (nat_idx),
    .perm_addr_i  (perm_addr),
    .addr_o       (route_addr)
  );

  assign mem_rd_addr_o = route_addr[0];
  assign mem_wr_addr_o = route_addr[1];

  turbo_hard_out #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W), .LLR_W(LLR_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (state == ST_OUTPUT),
    .llr_i        (llr_i),
    .llr_addr_o   (llr_addr_o),
    .last_o       (out_last),
    .hard_valid_o (hard_valid_o),
    .hard_bit_o   (hard_bit_o),
    .hard_idx_o   (hard_idx_o)
  );
endmodule

// File: rtl/turbo_iter_ctrl_chk.sv
module turbo_iter_ctrl_chk #(
  parameter int ITERS  = 6,
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dec_start_o,
  input logic              dec_half_o,
  input logic              apriori_zero_o,
  input logic [CNT_W-1:0]  iter_o,
  input logic              hard_valid_o,
  input logic [ADDR_W-1:0] hard_idx_o,
  input logic              done_o
);
  assert_iter_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_o < CNT_W'(ITERS));

  assert_iter_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iter_o != $past(iter_o)) |-> (iter_o == $past(iter_o) + 1'b1 || iter_o == '0));

  assert_start_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_start_o |=> !dec_start_o);

  assert_half_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_start_o |=> $stable(dec_half_o));

  assert_apz_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    apriori_zero_o |-> (iter_o == '0 && !dec_half_o));

  assert_out_seq_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hard_valid_o && $past(hard_valid_o)) |-> hard_idx_o == $past(hard_idx_o) + 1'b1);

  assert_out_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_valid_o |-> !dec_start_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hard_valid_o && (hard_idx_o == '1)) ##1 !done_o);
endmodule

bind turbo_iter_ctrl turbo_iter_ctrl_chk #(
  .ITERS(ITERS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dec_start_o    (dec_start_o),
  .dec_half_o     (dec_half_o),
  .apriori_zero_o (apriori_zero_o),
  .iter_o         (iter_o),
  .hard_valid_o   (hard_valid_o),
  .hard_idx_o     (hard_idx_o),
  .done_o         (done_o)
);

// File: tb/tb_turbo_iter_ctrl.sv
module tb_turbo_iter_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 64;
  localparam int AW  = 6;
  localparam int LW  = 8;
  localparam int NIT = 6;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic dec_done_i = 1'b0;
  logic dec_start_o, dec_half_o, apriori_zero_o, hard_valid_o, hard_bit_o, done_o;
  logic [2:0] iter_o;
  logic [AW-1:0] dec_rd_idx_i = '0, dec_wr_idx_i = '0;
  logic [AW-1:0] perm_rd_idx_o, perm_wr_idx_o, perm_rd_addr_i, perm_wr_addr_i;
  logic [AW-1:0] mem_rd_addr_o, mem_wr_addr_o, llr_addr_o, hard_idx_o;
  logic [LW-1:0] llr_i = '0;
  logic signed [LW-1:0] llr_mem [N];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [AW-1:0] perm(input logic [AW-1:0] k);
    return AW'((int'(k) * 5 + 3) % N);
  endfunction

  assign perm_rd_addr_i = perm(perm_rd_idx_o);
  assign perm_wr_addr_i = perm(perm_wr_idx_o);

  always @(posedge clk_i) llr_i <= llr_mem[llr_addr_o];

  turbo_iter_ctrl #(.FRAME_LEN(N), .ITERS(NIT), .LLR_W(LW)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_dec_start(output bit found);
    found = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (dec_start_o) begin found = 1'b1; break; end
      @(negedge clk_i);
    end
  endtask

  // drives one frame; lat = decoder busy cycles after its start
  task automatic run_frame(input int lat, input bit early_done, input bit busy_start, input string tag);
    bit found;
    int k, k2, cnt;
    bit seen_done;
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(dec_start_o == 1'b1, "R3", {tag, " first start two cycles after start_i"}, dec_start_o, 1);
    for (int h = 0; h < 2*NIT; h++) begin
      wait_dec_start(found);
      chk(found, "R2", {tag, " decoder start present"}, found, 1);
      if (!found) return;
      chk(dec_half_o == h[0], "R3", {tag, " half select at start"}, dec_half_o, h % 2);
      chk(int'(iter_o) == h/2, "R2", {tag, " iteration count"}, iter_o, h/2);
      chk(apriori_zero_o == (h == 0), "R4", {tag, " a-priori zero"}, apriori_zero_o, h == 0);
      if (early_done) dec_done_i = 1'b1;
      @(negedge clk_i);
      dec_done_i = 1'b0;
      chk(dec_start_o == 1'b0, "R3", {tag, " start is one cycle"}, dec_start_o, 0);
      k  = (h * 7 + 1) % N;
      k2 = (h * 11 + 5) % N;
      dec_rd_idx_i = AW'(k);
      dec_wr_idx_i = AW'(k2);
      #1;
      chk(mem_rd_addr_o == (h[0] ? perm(AW'(k)) : AW'(k)), "R5", {tag, " read address"},
          mem_rd_addr_o, h[0] ? perm(AW'(k)) : k);
      chk(mem_wr_addr_o == (h[0] ? perm(AW'(k2)) : AW'(k2)), "R5", {tag, " write address"},
          mem_wr_addr_o, h[0] ? perm(AW'(k2)) : k2);
      if (busy_start && h == 5) begin
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
      end
      repeat (lat) @(negedge clk_i);
      // R6: an early done must not have ended the half
      chk(dec_half_o == h[0] && !dec_start_o, "R6", {tag, " half held until done"}, dec_half_o, h % 2);
      chk(int'(iter_o) == h/2, "R9", {tag, " iteration not reset while busy"}, iter_o, h/2);
      dec_done_i = 1'b1;
      @(negedge clk_i);
      dec_done_i = 1'b0;
    end
    cnt = 0;
    seen_done = 1'b0;
    for (int c = 0; c < N + 8; c++) begin
      chk(!dec_start_o, "R2", {tag, " no extra decoder start"}, dec_start_o, 0);
      if (hard_valid_o) begin
        chk(int'(hard_idx_o) == cnt, "R7", {tag, " hard index order"}, hard_idx_o, cnt);
        chk(hard_bit_o == (llr_mem[cnt] >= 0), "R7", {tag, " hard bit sign"}, hard_bit_o, llr_mem[cnt] >= 0);
        cnt++;
      end
      if (done_o) begin
        seen_done = 1'b1;
        chk(cnt == N && hard_valid_o, "R8", {tag, " done with last bit"}, cnt, N);
        start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        chk(!done_o, "R8", {tag, " done is one cycle"}, done_o, 0);
        break;
      end
      @(negedge clk_i);
    end
    chk(seen_done, "R8", {tag, " done seen"}, seen_done, 1);
    for (int c = 0; c < 4; c++) begin
      chk(!dec_start_o && !hard_valid_o, "R9", {tag, " start during done ignored"}, dec_start_o, 0);
      @(negedge clk_i);
    end
  endtask

  task automatic test_reset;
    chk(!dec_start_o, "R1", "reset dec_start", dec_start_o, 0);
    chk(!done_o, "R1", "reset done", done_o, 0);
    chk(!hard_valid_o, "R1", "reset hard_valid", hard_valid_o, 0);
    chk(!dec_half_o && !apriori_zero_o, "R1", "reset half/apz", {dec_half_o, apriori_zero_o}, 0);
    chk(iter_o == 3'd0, "R1", "reset iter", iter_o, 0);
  endtask

  task automatic test_basic;    run_frame(2, 1'b0, 1'b0, "basic");  endtask
  task automatic test_early;    run_frame(4, 1'b1, 1'b0, "early");  endtask
  task automatic test_busy;     run_frame(1, 1'b0, 1'b1, "busy");   endtask

  initial begin
    for (int k = 0; k < N; k++) llr_mem[k] = LW'((k * 37) % 256 - 128);
    llr_mem[0] = 8'sd0;
    llr_mem[1] = -8'sd1;
    llr_mem[2] = 8'sd127;
    llr_mem[3] = -8'sd128;
    llr_mem[N-1] = 8'sd1;
    repeat (3) @(negedge clk_i);
    test_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    test_reset();
    test_basic();
    test_early();
    test_busy();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule